// File: doc/BRIEF.md
# Sparse-Mask Conversion Scan Sequencer

This block is the digital controller placed in front of a successive-approximation converter core. Software loads a channel-select mask and then writes a one to the enable bit. The sequencer then visits every selected channel once, starting from the lowest selected index and moving upward. For each visited channel it gives the core a one-cycle start pulse together with the channel index. It waits for the core's one-cycle done strobe and stores the returned sample in the result register that belongs to that channel.

Once the highest selected channel has been stored, the sequencer raises a single interrupt pulse. At that point busy clears and the enable bit stays at one. The sequencer then sits idle until software writes the enable bit again. The channel count and sample width are parameters, so the same code serves a six-channel and an eight-channel converter.

Top module: `adc_scan_seq`

## Requirements
- R1: Within one scan, start pulses carry the indices of the selected channels (bit i of the mask selects channel i) in strictly ascending order, each selected channel exactly once.
- R2: `conv_start` is high for one cycle per channel. The next start comes only after the done strobe for the previous channel has been accepted, and no start is issued while `busy` is 0.
- R3: A done strobe accepted for channel i writes `conv_data` into result slot i, which is bits [i*RES_W +: RES_W] of `results`. Every other slot keeps its value.
- R4: `irq` goes high for exactly one cycle per completed scan. This is the cycle in which the last result first reads back, and never earlier in the scan.
- R5: In the `irq` cycle, `busy` reads 0 for the first time and `en_q` stays 1.
- R6: After a scan ends, no start pulse is issued until `en_set` is pulsed again while idle.
- R7: An `en_set` pulse while the mask register holds zero sets `en_q` to 1, leaves `busy` at 0, issues no start and raises no `irq`.
- R8: `mask_wr` is ignored while `busy` is 1. While idle, it loads `mask_wdata` into `mask_q`. A scan uses the mask value held before the `en_set` edge.
- R9: `en_set` while `busy` is 1 has no effect: the scan is not restarted, lengthened or repeated.
- R10: A done strobe that arrives while no conversion is outstanding (idle, or in the cycle that carries the start pulse) is ignored.
- R11: A synchronous active-low reset clears all result slots, the mask, `en_q`, `busy` and `irq`, and returns the sequencer to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mask_wr | input | 1 | Write strobe for the channel-select mask |
| mask_wdata | input | NCH | Mask value to load; bit i selects channel i |
| en_set | input | 1 | Write of 1 to the enable bit (starts a scan) |
| conv_done | input | 1 | One-cycle done strobe from the converter core |
| conv_data | input | RES_W | Sample valid with `conv_done` |
| mask_q | output | NCH | Current mask register |
| en_q | output | 1 | Enable bit |
| busy | output | 1 | Scan in progress |
| conv_start | output | 1 | One-cycle start pulse to the core |
| conv_ch | output | CH_W | Channel index for the current conversion |
| irq | output | 1 | End-of-scan interrupt pulse |
| results | output | NCH*RES_W | Per-channel result registers, slot i at [i*RES_W +: RES_W] |

## Verification
On every cycle, the assertions check several properties: start pulses last one cycle, occur only while busy and rise in channel index within a scan; the interrupt lasts one cycle and coincides with busy falling while enable stays set; and the mask stays unchanged throughout a scan. Other behaviours only the bench scenarios can show. These are the exact visiting order for a given sparse mask and that each sample lands in its own slot while unselected slots stay untouched. They also include that stray done strobes and writes made during a scan are ignored, and that an empty mask or a mid-scan reset leaves the expected state. A behavioural queue model checks all outputs against these expectations on every clock.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NCH   = 6,
  parameter int RES_W = 12,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mask_wr,
  input  logic [NCH-1:0]       mask_wdata,
  input  logic                 en_set,
  input  logic                 conv_done,
  input  logic [RES_W-1:0]     conv_data,
  output logic [NCH-1:0]       mask_q,
  output logic                 en_q,
  output logic                 busy,
  output logic                 conv_start,
  output logic [CH_W-1:0]      conv_ch,
  output logic                 irq,
  output logic [NCH*RES_W-1:0] results
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_t;

  state_t         st;
  logic [NCH-1:0] pend;
  logic [NCH-1:0] cur_oh;
  logic [NCH-1:0] rest;
  logic           accept;

  function automatic logic [CH_W-1:0] low_idx(input logic [NCH-1:0] v);
    logic [CH_W-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (v[i]) r = CH_W'(i);
    return r;
  endfunction

  assign cur_oh     = pend & (~pend + NCH'(1));
  assign rest       = pend & ~cur_oh;
  assign conv_ch    = low_idx(pend);
  assign conv_start = (st == S_ISSUE);
  assign accept     = (st == S_WAIT) && conv_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pend   <= '0;
      mask_q <= '0;
      en_q   <= 1'b0;
      busy   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (st)
        S_IDLE: begin
          if (mask_wr) mask_q <= mask_wdata;
          if (en_set) begin
            en_q <= 1'b1;
            if (mask_q != '0) begin
              pend <= mask_q;
              busy <= 1'b1;
              st   <= S_ISSUE;
            end
          end
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: begin
          if (accept) begin
            pend <= rest;
            if (rest == '0) begin
              st   <= S_IDLE;
              busy <= 1'b0;
              irq  <= 1'b1;
            end else begin
              st <= S_ISSUE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        results[g*RES_W +: RES_W] <= '0;
      else if (accept && cur_oh[g])
        results[g*RES_W +: RES_W] <= conv_data;
    end
  end

endmodule

module adc_scan_seq_chk #(
  parameter int NCH   = 6,
  parameter int CH_W  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCH-1:0]  mask_q,
  input logic            en_q,
  input logic            busy,
  input logic            conv_start,
  input logic [CH_W-1:0] conv_ch,
  input logic            irq
);

  logic            past_ok;
  logic            seen_start;
  logic [CH_W-1:0] last_ch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      past_ok    <= 1'b0;
      seen_start <= 1'b0;
      last_ch    <= '0;
    end else begin
      past_ok <= 1'b1;
      if (!busy) seen_start <= 1'b0;
      else if (conv_start) begin
        seen_start <= 1'b1;
        last_ch    <= conv_ch;
      end
    end
  end

  // R1
  ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && seen_start) |-> (conv_ch > last_ch));

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);

  // R4
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5
  irq_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && irq) |-> ($fell(busy) && en_q));

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && busy && $past(busy)) |-> $stable(mask_q));

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH), .CH_W(CH_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mask_q(mask_q), .en_q(en_q), .busy(busy),
  .conv_start(conv_start), .conv_ch(conv_ch), .irq(irq)
);

// File: tb/adc_scan_seq_tb_top.sv
module adc_scan_seq_tb_top;
  localparam int NCH   = 6;
  localparam int RES_W = 12;
  localparam int CH_W  = 3;

  logic clk = 0, rst_n = 0;
  logic mask_wr = 0, en_set = 0, conv_done = 0;
  logic [NCH-1:0] mask_wdata = '0;
  logic [RES_W-1:0] conv_data = '0;
  logic [NCH-1:0] mask_q;
  logic en_q, busy, conv_start, irq;
  logic [CH_W-1:0] conv_ch;
  logic [NCH*RES_W-1:0] results;

  always #5 clk = ~clk;

  adc_scan_seq #(.NCH(NCH), .RES_W(RES_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .en_set(en_set), .conv_done(conv_done), .conv_data(conv_data),
    .mask_q(mask_q), .en_q(en_q), .busy(busy), .conv_start(conv_start),
    .conv_ch(conv_ch), .irq(irq), .results(results));

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model
  int m_q[$];
  int m_mask = 0, m_en = 0, m_busy = 0, m_irq = 0, m_phase = 0;
  int m_res[NCH];

  always @(posedge clk) begin
    int was_busy;
    if (!rst_n) begin
      m_q.delete();
      m_mask = 0; m_en = 0; m_busy = 0; m_irq = 0; m_phase = 0;
      foreach (m_res[i]) m_res[i] = 0;
    end else begin
      was_busy = m_busy;
      m_irq = 0;
      if (m_phase == 2) m_phase = 1;
      else if (m_phase == 1 && conv_done) begin
        m_res[m_q[0]] = int'(conv_data);
        void'(m_q.pop_front());
        if (m_q.size() == 0) begin m_busy = 0; m_irq = 1; m_phase = 0; end
        else m_phase = 2;
      end
      if (!was_busy) begin
        int old_mask;
        old_mask = m_mask;
        if (mask_wr) m_mask = int'(mask_wdata);
        if (en_set) begin
          m_en = 1;
          if (old_mask != 0) begin
            for (int c = 0; c < NCH; c++) if (old_mask[c]) m_q.push_back(c);
            m_busy = 1; m_phase = 2;
          end
        end
      end
    end
  end

  // converter core model
  int lat = 0, seq = 0, lat_cfg = 1;
  bit stray = 0;
  int start_log[$];
  int irq_cnt = 0;
  always @(negedge clk) begin
    conv_done <= 0;
    if (conv_start) begin
      lat <= lat_cfg + (seq % 3);
      if (stray) begin conv_done <= 1; conv_data <= 12'hBAD; end
    end else if (lat > 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        conv_done <= 1;
        conv_data <= RES_W'(seq * 37 + int'(conv_ch) + 1);
        seq <= seq + 1;
      end
    end
  end

  // per-clock comparison
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(busy == (m_busy != 0), "R5 busy", busy, m_busy);
      chk(en_q == (m_en != 0), "R9 en_q", en_q, m_en);
      chk(irq == (m_irq != 0), "R4 irq", irq, m_irq);
      chk(conv_start == (m_phase == 2), "R2 start", conv_start, m_phase == 2);
      if (m_phase == 2) chk(int'(conv_ch) == m_q[0], "R1 channel", conv_ch, m_q[0]);
      chk(int'(mask_q) == m_mask, "R8 mask", mask_q, m_mask);
      for (int i = 0; i < NCH; i++)
        chk(int'(results[i*RES_W +: RES_W]) == m_res[i], "R3 slot", results[i*RES_W +: RES_W], m_res[i]);
      if (conv_start) start_log.push_back(int'(conv_ch));
      if (irq) irq_cnt++;
    end
    if (cyc > 100000) begin
      chk(0, "watchdog", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_mask(input int v);
    mask_wr = 1; mask_wdata = NCH'(v); tick(1); mask_wr = 0;
  endtask

  task automatic go();
    en_set = 1; tick(1); en_set = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    tick(1);
    while (busy && n < 2000) begin tick(1); n++; end
    tick(1);
  endtask

  initial begin
    tick(3);
    // R11 reset state
    chk(busy == 0 && en_q == 0 && irq == 0 && mask_q == 0 && results == 0, "R11 reset", busy, 0);
    rst_n = 1; tick(1);

    // R1 R3 R4 R5: sparse mask 0x2A
    wr_mask('h2A); start_log.delete(); irq_cnt = 0;
    go(); wait_idle();
    chk(start_log.size() == 3 && start_log[0] == 1 && start_log[1] == 3 && start_log[2] == 5,
        "R1 order 1,3,5", start_log.size(), 3);
    chk(irq_cnt == 1, "R4 one irq", irq_cnt, 1);
    chk(busy == 0 && en_q == 1, "R5 end state", {busy, en_q}, 1);
    chk(results[0 +: RES_W] == 0 && results[2*RES_W +: RES_W] == 0 && results[4*RES_W +: RES_W] == 0,
        "R3 unselected untouched", results, 0);
    chk(results[1*RES_W +: RES_W] != 0 && results[5*RES_W +: RES_W] != 0, "R3 selected written", results, 1);

    // R6: no restart without new enable write
    start_log.delete(); tick(25);
    chk(start_log.size() == 0, "R6 idle", start_log.size(), 0);

    // R7: empty mask
    wr_mask(0); irq_cnt = 0; go(); tick(10);
    chk(start_log.size() == 0 && irq_cnt == 0 && busy == 0 && en_q == 1, "R7 empty mask", start_log.size(), 0);

    // R8 R9: writes during busy scan, full mask
    wr_mask('h3F); start_log.delete(); irq_cnt = 0; lat_cfg = 3;
    go(); tick(2);
    wr_mask('h01); go(); tick(4); go();
    wait_idle();
    chk(mask_q == 6'h3F, "R8 mask kept", mask_q, 'h3F);
    chk(start_log.size() == 6 && irq_cnt == 1, "R9 no restart", start_log.size(), 6);

    // R10: stray done strobes while idle and in start cycle
    conv_data = 12'h777; conv_done = 1; tick(1); conv_done = 0; tick(2);
    stray = 1; wr_mask('h24); start_log.delete(); go(); wait_idle(); stray = 0;
    chk(results[2*RES_W +: RES_W] != 12'hBAD && results[5*RES_W +: RES_W] != 12'hBAD, "R10 stray", results, 0);
    chk(start_log.size() == 2 && start_log[0] == 2, "R1 order 2,5", start_log.size(), 2);

    // single-channel edges
    lat_cfg = 1;
    wr_mask('h20); start_log.delete(); irq_cnt = 0; go(); wait_idle();
    chk(start_log.size() == 1 && start_log[0] == 5 && irq_cnt == 1, "R4 top channel", start_log.size(), 1);
    wr_mask('h01); start_log.delete(); go(); wait_idle();
    chk(start_log.size() == 1 && start_log[0] == 0, "R1 bottom channel", start_log.size(), 1);

    // R11 reset mid-scan
    wr_mask('h3F); go(); tick(5);
    rst_n = 0; tick(1);
    chk(busy == 0 && en_q == 0 && mask_q == 0 && results == 0 && irq == 0, "R11 mid reset", results, 0);
    rst_n = 1; tick(5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule